// File: doc/BRIEF.md
# Scan-Chain Roll-Forward Recovery Sequencer for Triple Redundancy

This block repairs a triple-redundant system after a separate comparison stage has worked out which of the three copies hold a corrupted state. It takes a three-bit fault map and the three pairwise mismatch counts from that stage. It then turns on all three test scan chains for exactly one chain length. Each corrupted copy's scan input is routed from a healthy copy's scan output, so the healthy state is copied in serially. Each healthy copy's scan input is fed from its own scan output, so its state goes round the ring unchanged.

During the shift the sequencer keeps comparing the three scan-out bits pair by pair. Each mismatch takes one off the matching pair count. When the shift ends, every count must be exactly zero, and no mismatch may have arrived while a count was already zero. Otherwise a new upset struck during the copy, and the error flag is raised. A short history records which module was repaired most recently and how many repairs in a row have hit that module. When the run reaches a set limit, the module is declared permanently faulty and excluded. The sequencer then parks, so the surviving pair runs as master and checker.

States: `ST_IDLE` waits for a start. `ST_SHIFT` copies and compares for `CHAIN_LEN` cycles. `ST_CHECK` judges the counters for one cycle. `ST_DEGRADED` is the final state after a permanent fault. The transitions are:
- start-accept: `ST_IDLE` to `ST_SHIFT`.
- all-faulty reject: `ST_IDLE` to `ST_IDLE`, with the error flag set.
- permanent declare: `ST_IDLE` to `ST_DEGRADED`.
- last-bit: `ST_SHIFT` to `ST_CHECK`.
- verdict: `ST_CHECK` to `ST_IDLE`.
- reset: any state to `ST_IDLE`.

Top module: `tmr_recovery_seq`

## Requirements
- R1: After reset, and in `ST_IDLE`, the following hold. `scan_en_o` is low. Every select carries its own module index, using the encoding 0, 1, 2 for modules 0, 1, 2. Both result flags are low, `perm_fault_o` is low, and `excluded_o` is 3, meaning no module.
- R2: A start accepted in `ST_IDLE` captures the fault map and the three counts. In the fault map, bit k set means module k is faulty. Unless R7 or R9 applies, `scan_en_o` is high for exactly `CHAIN_LEN` consecutive cycles, beginning in the cycle after the start was sampled.
- R3: During the shift, the select of every fault-free module equals its own index.
- R4: During the shift, the select of every faulty module equals the lowest-numbered fault-free module. With two faulty modules, both take their data from the one healthy module. At the end of the shift, each faulty chain holds the healthy chain's former content.
- R5: On every shift cycle, the sequencer compares the scan-out bits of pairs (0,1), (0,2) and (1,2). These pairs are loaded from `cnt01_i`, `cnt02_i` and `cnt12_i`. A mismatch lowers that pair's count by one. A mismatch that arrives while the count is zero marks the pair as underflowed.
- R6: One cycle after the shift, `rec_ok_o` rises if all three counts are zero and no pair underflowed. Otherwise `rec_err_o` rises. Both flags hold until the next accepted start clears them, and they are never high together.
- R7: A start with the fault map 3'b111 performs no shift. It sets `rec_err_o` in the next cycle and leaves the repair history untouched.
- R8: A start naming exactly one faulty module updates the history as follows. If that module is the most recently repaired one, the consecutive count goes up by one. Otherwise the module becomes the most recent one and the count becomes 1. A two-module start clears the history. An all-clear fault map (3'b000) leaves the history as it is.
- R9: When the consecutive count would reach `PERM_LIMIT`, no shift takes place. Instead `perm_fault_o` rises, `excluded_o` takes that module's index, and both result flags are cleared.
- R10: In `ST_DEGRADED`, starts are ignored. `scan_en_o` stays low, the selects keep their own indices, and `perm_fault_o` and `excluded_o` hold until reset.
- R11: A start raised while a shift or a check is in progress is ignored. The shift length and the verdict stay those of the start that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a recovery using the present fault map and counts |
| fmr_i | input | 3 | Fault map, bit k set means module k is faulty |
| cnt01_i | input | CNT_W | Mismatch count between modules 0 and 1 |
| cnt02_i | input | CNT_W | Mismatch count between modules 0 and 2 |
| cnt12_i | input | CNT_W | Mismatch count between modules 1 and 2 |
| scan_out_i | input | 3 | Scan-chain output bit of each module, bit k for module k |
| scan_en_o | output | 1 | Scan enable for all three chains |
| sel0_o | output | 2 | Source module index for module 0's scan input |
| sel1_o | output | 2 | Source module index for module 1's scan input |
| sel2_o | output | 2 | Source module index for module 2's scan input |
| rec_ok_o | output | 1 | Last recovery ended with every count at zero |
| rec_err_o | output | 1 | Last recovery failed its count check, or all modules were faulty |
| perm_fault_o | output | 1 | A module has been declared permanently faulty |
| excluded_o | output | 2 | Index of the excluded module, 3 if none |

## Verification
The checker watches these on every cycle:
- The selects always form a valid routing during a shift: every select names a module that feeds itself.
- The scan enable only ever rises after a start.
- Each shift burst is exactly `CHAIN_LEN` cycles long, measured by a run counter.
- A verdict always follows the end of a shift, and the two flags are never high together.
- An all-faulty start is rejected.
- The permanent flag and the excluded index stay fixed once set.

Only the bench scenarios can show the rest:
- The chains end up holding the healthy content.
- The verdict is correct for exact counts, for counts one too high, for counts one too low, and for an upset injected mid-shift.
- The repair history counts consecutive faults across interleaved single-module and two-module repairs.

// File: rtl/tmr_rec_pkg.sv
package tmr_rec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_CHECK,
        ST_DEGRADED
    } seq_state_e;

    typedef logic [1:0] mod_idx_t;

    localparam mod_idx_t NO_MODULE = 2'd3;

    // Lowest-numbered module whose fault bit is clear.
    function automatic mod_idx_t first_clean(input logic [2:0] fmap);
        mod_idx_t r;
        r = NO_MODULE;
        for (int k = 2; k >= 0; k--) begin
            if (!fmap[k]) r = mod_idx_t'(k);
        end
        return r;
    endfunction

    // Index of the lowest set fault bit (the only one for a single fault).
    function automatic mod_idx_t first_faulty(input logic [2:0] fmap);
        mod_idx_t r;
        r = NO_MODULE;
        for (int k = 2; k >= 0; k--) begin
            if (fmap[k]) r = mod_idx_t'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/tmr_scan_router.sv
module tmr_scan_router
    import tmr_rec_pkg::*;
(
    input  logic            active_i,
    input  logic [2:0]      fmap_i,
    output logic [2:0][1:0] sel_o
);

    mod_idx_t src;

    assign src = first_clean(fmap_i);

    // Faulty chains take the healthy source while copying; all others loop back.
    for (genvar k = 0; k < 3; k++) begin : g_route
        assign sel_o[k] = (active_i && fmap_i[k]) ? src : mod_idx_t'(k);
    end

endmodule

// File: rtl/tmr_pair_tally.sv
module tmr_pair_tally #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             step_i,
    input  logic             bit_a_i,
    input  logic             bit_b_i,
    output logic             zero_o,
    output logic             under_o
);

    logic [CNT_W-1:0] left_q;
    logic             under_q;
    logic             differ;

    assign differ = bit_a_i ^ bit_b_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            under_q <= 1'b0;
        end else if (load_i) begin
            left_q  <= load_val_i;
            under_q <= 1'b0;
        end else if (step_i && differ) begin
            if (left_q == '0) begin
                under_q <= 1'b1;
            end else begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign zero_o  = (left_q == '0);
    assign under_o = under_q;

endmodule

// File: rtl/tmr_fault_history.sv
module tmr_fault_history
    import tmr_rec_pkg::*;
#(
    parameter int PERM_LIMIT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_i,
    input  logic [2:0] fmap_i,
    output logic       declare_o,
    output logic       perm_o,
    output mod_idx_t   excl_o
);

    localparam int NCF_W = $clog2(PERM_LIMIT + 1) + 1;

    mod_idx_t         recent_q;
    logic [NCF_W-1:0] run_q;
    logic             perm_q;
    mod_idx_t         excl_q;

    logic             single;
    logic             multi;
    mod_idx_t         hit_idx;
    logic [NCF_W-1:0] run_next;

    assign single   = ($countones(fmap_i) == 1);
    assign multi    = ($countones(fmap_i) >= 2);
    assign hit_idx  = first_faulty(fmap_i);
    assign run_next = (hit_idx == recent_q) ? run_q + 1'b1 : NCF_W'(1);
    assign declare_o = single && (int'(run_next) >= PERM_LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recent_q <= NO_MODULE;
            run_q    <= '0;
            perm_q   <= 1'b0;
            excl_q   <= NO_MODULE;
        end else if (upd_i) begin
            if (single) begin
                recent_q <= hit_idx;
                run_q    <= run_next;
                if (declare_o) begin
                    perm_q <= 1'b1;
                    excl_q <= hit_idx;
                end
            end else if (multi) begin
                recent_q <= NO_MODULE;
                run_q    <= '0;
            end
        end
    end

    assign perm_o = perm_q;
    assign excl_o = excl_q;

endmodule

// File: rtl/tmr_recovery_seq.sv
module tmr_recovery_seq
    import tmr_rec_pkg::*;
#(
    parameter int CHAIN_LEN  = 16,
    parameter int CNT_W      = $clog2(CHAIN_LEN + 1),
    parameter int PERM_LIMIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       fmr_i,
    input  logic [CNT_W-1:0] cnt01_i,
    input  logic [CNT_W-1:0] cnt02_i,
    input  logic [CNT_W-1:0] cnt12_i,
    input  logic [2:0]       scan_out_i,
    output logic             scan_en_o,
    output logic [1:0]       sel0_o,
    output logic [1:0]       sel1_o,
    output logic [1:0]       sel2_o,
    output logic             rec_ok_o,
    output logic             rec_err_o,
    output logic             perm_fault_o,
    output logic [1:0]       excluded_o
);

    localparam int              BIT_W      = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(CHAIN_LEN - 1);
    localparam logic [2:0]      ALL_FAULTY = 3'b111;

    seq_state_e       state_q, state_d;
    logic [2:0]       fmap_q;
    logic [BIT_W-1:0] bit_q;
    logic             ok_q, err_q;

    logic             accept;
    logic             shifting;
    logic             all_clean;
    logic             declare;
    logic             perm_w;
    mod_idx_t         excl_w;
    logic [2:0]       pair_zero;
    logic [2:0]       pair_under;
    logic [2:0][1:0]  sel_w;

    assign accept   = (state_q == ST_IDLE) && start_i;
    assign shifting = (state_q == ST_SHIFT);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (fmr_i == ALL_FAULTY) state_d = ST_IDLE;
                    else if (declare)        state_d = ST_DEGRADED;
                    else                     state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (bit_q == LAST_BIT) state_d = ST_CHECK;
            end
            ST_CHECK:    state_d = ST_IDLE;
            ST_DEGRADED: state_d = ST_DEGRADED;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Captured fault map, bit position, verdict flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmap_q <= '0;
            bit_q  <= '0;
            ok_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (accept) begin
                fmap_q <= fmr_i;
                bit_q  <= '0;
                ok_q   <= 1'b0;
                err_q  <= (fmr_i == ALL_FAULTY);
            end else if (shifting) begin
                bit_q <= bit_q + 1'b1;
            end
            if (state_q == ST_CHECK) begin
                ok_q  <= all_clean;
                err_q <= !all_clean;
            end
        end
    end

    // One tally per module pair: (0,1), (0,2), (1,2)
    for (genvar p = 0; p < 3; p++) begin : g_pair
        localparam int A_IDX = (p == 2) ? 1 : 0;
        localparam int B_IDX = (p == 0) ? 1 : 2;
        logic [CNT_W-1:0] init_val;
        assign init_val = (p == 0) ? cnt01_i : (p == 1) ? cnt02_i : cnt12_i;

        tmr_pair_tally #(
            .CNT_W(CNT_W)
        ) tally_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (accept),
            .load_val_i(init_val),
            .step_i    (shifting),
            .bit_a_i   (scan_out_i[A_IDX]),
            .bit_b_i   (scan_out_i[B_IDX]),
            .zero_o    (pair_zero[p]),
            .under_o   (pair_under[p])
        );
    end

    assign all_clean = (&pair_zero) && !(|pair_under);

    tmr_scan_router router_i (
        .active_i(shifting),
        .fmap_i  (fmap_q),
        .sel_o   (sel_w)
    );

    tmr_fault_history #(
        .PERM_LIMIT(PERM_LIMIT)
    ) history_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_i    (accept && (fmr_i != ALL_FAULTY)),
        .fmap_i   (fmr_i),
        .declare_o(declare),
        .perm_o   (perm_w),
        .excl_o   (excl_w)
    );

    // Outputs
    always_comb begin
        scan_en_o    = shifting;
        sel0_o       = sel_w[0];
        sel1_o       = sel_w[1];
        sel2_o       = sel_w[2];
        rec_ok_o     = ok_q;
        rec_err_o    = err_q;
        perm_fault_o = perm_w;
        excluded_o   = excl_w;
    end

endmodule

// File: rtl/tmr_recovery_seq_chk.sv
module tmr_recovery_seq_chk
    import tmr_rec_pkg::*;
#(
    parameter int CHAIN_LEN = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [2:0] fmr_i,
    input logic       scan_en_o,
    input logic [1:0] sel0_o,
    input logic [1:0] sel1_o,
    input logic [1:0] sel2_o,
    input logic       rec_ok_o,
    input logic       rec_err_o,
    input logic       perm_fault_o,
    input logic [1:0] excluded_o,
    input seq_state_e state_q
);

    localparam int RUN_W = $clog2(CHAIN_LEN + 2) + 1;

    logic [RUN_W-1:0] run_q;
    logic [2:0][1:0]  s;

    assign s = {sel2_o, sel1_o, sel0_o};

    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= '0;
        else if (scan_en_o) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    // R3 R4: every source named during a shift feeds itself
    assert_route_consistent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en_o |-> (s[0] != 2'd3) && (s[1] != 2'd3) && (s[2] != 2'd3)
                      && (s[s[0]] == s[0]) && (s[s[1]] == s[1]) && (s[s[2]] == s[2]));

    // R2: a shift only starts after a start request
    assert_shift_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_en_o) |-> $past(start_i));

    // R2: every burst lasts exactly CHAIN_LEN cycles
    assert_burst_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en_o && (run_q != '0)) |-> (run_q == RUN_W'(CHAIN_LEN)));

    // R6: a verdict follows every shift
    assert_verdict_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_en_o) |=> (rec_ok_o || rec_err_o));

    // R6: flags are exclusive
    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rec_ok_o && rec_err_o));

    // R7: all-faulty start is rejected
    assert_all_faulty_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && start_i && (fmr_i == 3'b111)) |=> (rec_err_o && !scan_en_o));

    // R9: permanent flag and excluded index agree
    assert_excluded_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        perm_fault_o == (excluded_o != 2'd3));

    // R10: degraded state is frozen
    assert_degraded_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        perm_fault_o |=> perm_fault_o && $stable(excluded_o) && !scan_en_o
                         && (sel0_o == 2'd0) && (sel1_o == 2'd1) && (sel2_o == 2'd2));

endmodule

bind tmr_recovery_seq tmr_recovery_seq_chk #(
    .CHAIN_LEN(CHAIN_LEN)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .fmr_i       (fmr_i),
    .scan_en_o   (scan_en_o),
    .sel0_o      (sel0_o),
    .sel1_o      (sel1_o),
    .sel2_o      (sel2_o),
    .rec_ok_o    (rec_ok_o),
    .rec_err_o   (rec_err_o),
    .perm_fault_o(perm_fault_o),
    .excluded_o  (excluded_o),
    .state_q     (state_q)
);

// File: tb/tmr_recovery_seq_tb_top.sv
module tmr_recovery_seq_tb_top;

    localparam int L   = 16;
    localparam int CW  = $clog2(L + 1);
    localparam int LIM = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i;
    logic [2:0]    fmr_i;
    logic [CW-1:0] cnt01_i, cnt02_i, cnt12_i;
    logic [2:0]    scan_out_i;
    logic          scan_en_o;
    logic [1:0]    sel0_o, sel1_o, sel2_o;
    logic          rec_ok_o, rec_err_o, perm_fault_o;
    logic [1:0]    excluded_o;

    always #2 clk = ~clk;

    tmr_recovery_seq #(
        .CHAIN_LEN (L),
        .CNT_W     (CW),
        .PERM_LIMIT(LIM)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fmr_i(fmr_i),
        .cnt01_i(cnt01_i), .cnt02_i(cnt02_i), .cnt12_i(cnt12_i),
        .scan_out_i(scan_out_i), .scan_en_o(scan_en_o),
        .sel0_o(sel0_o), .sel1_o(sel1_o), .sel2_o(sel2_o),
        .rec_ok_o(rec_ok_o), .rec_err_o(rec_err_o),
        .perm_fault_o(perm_fault_o), .excluded_o(excluded_o)
    );

    // Behavioural scan chains of the three modules
    logic [L-1:0] chain    [3];
    logic [L-1:0] load_val [3];
    logic [L-1:0] img      [3];
    logic         load_req;
    logic [2:0]   flip_req;
    logic [1:0]   selv     [3];

    assign selv[0] = sel0_o;
    assign selv[1] = sel1_o;
    assign selv[2] = sel2_o;
    assign scan_out_i = {chain[2][L-1], chain[1][L-1], chain[0][L-1]};

    always @(posedge clk) begin
        for (int k = 0; k < 3; k++) begin
            if (load_req)
                chain[k] <= load_val[k];
            else if (scan_en_o)
                chain[k] <= {chain[k][L-2:0], chain[selv[k]][L-1]}
                            ^ (flip_req[k] ? {1'b1, {(L-1){1'b0}}} : {L{1'b0}});
        end
    end

    int n_checks = 0;
    int n_errs   = 0;

    // Reference model state
    int m_recent = -1;
    int m_run    = 0;
    bit m_perm   = 0;
    int m_excl   = 3;
    bit m_ok     = 0;
    bit m_err    = 0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int lowest_clean(input logic [2:0] f);
        for (int k = 0; k < 3; k++) if (!f[k]) return k;
        return 3;
    endfunction

    task automatic check_idle_outputs(input string req);
        check(req, "scan_en idle", scan_en_o, 0);
        check(req, "sel0 idle", sel0_o, 0);
        check(req, "sel1 idle", sel1_o, 1);
        check(req, "sel2 idle", sel2_o, 2);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start_i = 1'b0; load_req = 1'b0; flip_req = '0;
        fmr_i = '0; cnt01_i = '0; cnt02_i = '0; cnt12_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_recent = -1; m_run = 0; m_perm = 0; m_excl = 3; m_ok = 0; m_err = 0;
        @(negedge clk);
        check_idle_outputs("R1");
        check("R1", "rec_ok reset", rec_ok_o, 0);
        check("R1", "rec_err reset", rec_err_o, 0);
        check("R1", "perm reset", perm_fault_o, 0);
        check("R1", "excluded reset", excluded_o, 3);
    endtask

    // perturb: 0 exact, 1 one too high, 2 one too low; flip_mod >= 0 upsets that clean chain mid-shift
    task automatic do_trial(input logic [2:0] fmr, input int perturb, input int flip_mod, input bit busy);
        int  t [3];
        bit  will_shift;
        int  exp_scan;
        int  seen_scan;
        int  src;
        int  nn;
        logic [L-1:0] exp_chain [3];
        string out_req;

        t[0] = $countones(img[0] ^ img[1]);
        t[1] = $countones(img[0] ^ img[2]);
        t[2] = $countones(img[1] ^ img[2]);
        if (perturb == 1) t[0] = t[0] + 1;
        if (perturb == 2) t[0] = (t[0] > 0) ? t[0] - 1 : t[0] + 1;
        src = lowest_clean(fmr);

        // Prediction
        will_shift = 0;
        out_req = (fmr == 3'b111) ? "R7" : "R5 R6";
        if (m_perm) begin
            out_req = "R10";
        end else if (fmr == 3'b111) begin
            m_ok = 0; m_err = 1;
        end else if ($countones(fmr) == 1) begin
            nn = (src == 0 && fmr == 3'b001) ? 0 : 0;
            nn = (int'(lowest_clean(~fmr)) == m_recent) ? m_run + 1 : 1;
            m_recent = lowest_clean(~fmr);
            m_run = nn;
            if (nn >= LIM) begin
                m_perm = 1; m_excl = m_recent; m_ok = 0; m_err = 0;
                out_req = "R8 R9";
            end else begin
                will_shift = 1;
            end
        end else begin
            if (fmr != 3'b000) begin m_recent = -1; m_run = 0; end
            will_shift = 1;
        end
        exp_scan = will_shift ? L : 0;
        if (will_shift) begin
            m_ok  = (perturb == 0) && (flip_mod < 0);
            m_err = !m_ok;
        end
        for (int k = 0; k < 3; k++)
            exp_chain[k] = (will_shift && fmr[k]) ? img[src] : img[k];

        // Stimulus
        @(negedge clk);
        for (int k = 0; k < 3; k++) load_val[k] = img[k];
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        fmr_i = fmr;
        cnt01_i = CW'(t[0]); cnt02_i = CW'(t[1]); cnt12_i = CW'(t[2]);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        seen_scan = 0;
        for (int i = 0; i < L + 5; i++) begin
            if (scan_en_o) seen_scan++;
            if (i == 1 && will_shift) begin
                for (int k = 0; k < 3; k++)
                    check(fmr[k] ? "R4" : "R3", $sformatf("select of module %0d", k),
                          selv[k], fmr[k] ? src : k);
            end
            flip_req = (i == 2 && flip_mod >= 0) ? 3'(1 << flip_mod) : 3'b000;
            if (busy && i == 4) begin start_i = 1'b1; fmr_i = ~fmr; end
            if (busy && i == 5) start_i = 1'b0;
            @(negedge clk);
        end
        flip_req = '0;

        check(busy ? "R2 R11" : (m_perm ? "R9 R10" : "R2"), "shift cycles", seen_scan, exp_scan);
        check(out_req, "rec_ok", rec_ok_o, m_ok);
        check(out_req, "rec_err", rec_err_o, m_err);
        check("R8 R9", "perm_fault", perm_fault_o, m_perm);
        check("R9", "excluded", excluded_o, m_excl);
        check_idle_outputs(m_perm ? "R10" : "R1");
        if (flip_mod < 0) begin
            for (int k = 0; k < 3; k++)
                check(will_shift ? (fmr[k] ? "R4" : "R3") : "R7 R10",
                      $sformatf("chain %0d content", k), chain[k], exp_chain[k]);
        end
    endtask

    function automatic logic [L-1:0] nz_mask();
        logic [L-1:0] m;
        m = L'($urandom);
        if (m == '0) m = 1;
        return m;
    endfunction

    task automatic make_images(input logic [2:0] fmr);
        logic [L-1:0] g;
        g = L'($urandom);
        for (int k = 0; k < 3; k++) img[k] = fmr[k] ? (g ^ nz_mask()) : g;
    endtask

    // Watchdog
    initial begin
        #(4 * 150000);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd9137));
        load_req = 1'b0;
        flip_req = '0;
        for (int k = 0; k < 3; k++) load_val[k] = '0;
        do_reset();

        // Directed corner cases
        make_images(3'b010); do_trial(3'b010, 0, -1, 0);  // single, exact
        make_images(3'b101); do_trial(3'b101, 0, -1, 0);  // double, source module 1
        make_images(3'b011); do_trial(3'b011, 0, -1, 0);  // double, source module 2
        make_images(3'b111); do_trial(3'b111, 0, -1, 0);  // all faulty
        make_images(3'b100); do_trial(3'b100, 1, -1, 0);  // leftover count
        make_images(3'b001); do_trial(3'b001, 2, -1, 0);  // underflow
        make_images(3'b010); do_trial(3'b010, 0, 0, 0);   // upset on clean chain mid-shift
        make_images(3'b000); do_trial(3'b000, 0, -1, 1);  // scrub, busy start ignored

        // Permanent fault after consecutive repeats
        do_reset();
        for (int r = 0; r < LIM; r++) begin
            make_images(3'b100); do_trial(3'b100, 0, -1, 0);
        end
        make_images(3'b001); do_trial(3'b001, 0, -1, 0);  // ignored while degraded

        // History broken by a double fault and a different module
        do_reset();
        make_images(3'b001); do_trial(3'b001, 0, -1, 0);
        make_images(3'b001); do_trial(3'b001, 0, -1, 0);
        make_images(3'b110); do_trial(3'b110, 0, -1, 0);
        make_images(3'b001); do_trial(3'b001, 0, -1, 0);
        make_images(3'b010); do_trial(3'b010, 0, -1, 0);
        make_images(3'b001); do_trial(3'b001, 0, -1, 0);
        make_images(3'b001); do_trial(3'b001, 0, -1, 0);
        make_images(3'b001); do_trial(3'b001, 0, -1, 0);  // reaches limit

        // Random trials
        do_reset();
        for (int n = 0; n < 40; n++) begin
            logic [2:0] f;
            int pt;
            f  = 3'($urandom % 8);
            pt = ($urandom % 4 == 0) ? int'(1 + $urandom % 2) : 0;
            make_images(f);
            do_trial(f, pt, -1, 0);
            if (m_perm) do_reset();
        end

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule